// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

The controller collects eight rising-edge interrupt requests and gives the processor one interrupt line. Requests that arrive are held as pending. The controller picks the most urgent pending line that is not masked and compares it with the sources already being serviced. If the new line ranks above all of them, the controller raises `intr`. The processor answers with a one-cycle `inta` pulse. One cycle later the controller presents an 8-bit vector for one cycle. The vector is a programmable 5-bit base followed by the 3-bit source number.

Lines are ranked in one of two ways. In the fixed ordering line 0 ranks highest and line 7 lowest. In the rotating ordering, the source most recently released by an end-of-interrupt command drops to the bottom, and the line after it moves to the top.

A small write port configures the controller and accepts the end-of-interrupt command. The port has no read side. The acknowledge sequence is run by a three-state machine:

- `ST_IDLE` (intr low) moves to `ST_RAISE` when an eligible request exists.
- `ST_RAISE` (intr high) moves to `ST_VECTOR` on an accepted acknowledge. It moves back to `ST_IDLE` if the eligible request disappears.
- `ST_VECTOR` (vector strobe high) always returns to `ST_IDLE` after one cycle.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `intr`, `vec_valid` and `vec_out` are zero. Nothing is pending and nothing is in service. No line is masked, the base is 0 and the fixed ordering is selected.
- R2: A 0-to-1 transition on `irq_in[i]` makes line i pending. A line held high does not become pending again. A second rising edge while the line is still pending is absorbed, so it yields only one acknowledge.
- R3: Writing address 0 sets the mask, where bit i = 1 disables line i. A masked pending line never raises `intr`. It stays pending and is served once its mask bit is cleared.
- R4: An eligible rising edge sampled at clock edge k raises `intr` after edge k+1. `intr` then stays high until it is acknowledged.
- R5: If `inta` is high while `intr` is high, `vec_valid` is high for exactly the next cycle. During that cycle `vec_out` = {base[4:0], source[2:0]}. The base is written at address 1 from `cfg_wdata[4:0]`.
- R6: In the fixed ordering (address 2, `cfg_wdata[0]` = 0), line 0 ranks highest and line 7 lowest.
- R7: A pending line raises `intr` only if it ranks strictly above every in-service source. This rule applies in both orderings.
- R8: A write to address 3 (end of interrupt) clears the in-service bit of the highest-ranking in-service source. After that, lower pending lines can be served.
- R9: In the rotating ordering (address 2, `cfg_wdata[0]` = 1), an end-of-interrupt that releases source k makes k lowest. The new ranking is k+1, k+2, ... up to k (mod 8).
- R10: An acknowledge clears the winner's pending bit and sets its in-service bit. Without a new edge, the same source does not interrupt again.
- R11: An end-of-interrupt written while nothing is in service has no effect, and the rotation point does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Edge-triggered request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 mask, 1 vector base, 2 ordering mode, 3 end of interrupt |
| cfg_wdata | input | 8 | Configuration write data |
| inta | input | 1 | Processor acknowledge, one-cycle pulse |
| intr | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector strobe, one cycle |
| vec_out | output | 8 | Vector of the acknowledged source, zero otherwise |

## Verification
The assertions assume that `inta` is a single-cycle pulse given only while `intr` is high. They also assume that end-of-interrupt writes arrive only outside the acknowledge cycle. The stimulus waits to see `intr` before it pulses `inta`, and it issues configuration writes only when no acknowledge is in flight. Request lines change only at falling edges and are held for at least two cycles, so every rising edge is sampled.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    localparam int unsigned NSRC   = 8;
    localparam int unsigned IDW    = $clog2(NSRC);
    localparam int unsigned VECW   = 8;
    localparam int unsigned BASEW  = VECW - IDW;
    localparam int unsigned CFGAW  = 2;

    localparam logic [CFGAW-1:0] CFG_MASK = 2'd0;
    localparam logic [CFGAW-1:0] CFG_BASE = 2'd1;
    localparam logic [CFGAW-1:0] CFG_MODE = 2'd2;
    localparam logic [CFGAW-1:0] CFG_EOI  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAISE  = 2'd1,
        ST_VECTOR = 2'd2
    } ack_state_t;
endpackage

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] lowest,
    output logic          found,
    output logic [IW-1:0] id,
    output logic [IW-1:0] rank
);
    // Rank k is the k-th line after the lowest-priority line, wrapping round.
    always_comb begin
        found = 1'b0;
        id    = '0;
        rank  = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int unsigned sel;
            sel = (int'(lowest) + 1 + k) % N;
            if (req[sel]) begin
                found = 1'b1;
                id    = IW'(sel);
                rank  = IW'(k);
            end
        end
    end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_id,
    output logic [N-1:0]  pend
);
    logic [N-1:0] irq_q;
    logic [N-1:0] rise;
    logic [N-1:0] clr_vec;

    assign rise = irq_in & ~irq_q;

    always_comb begin
        clr_vec = '0;
        if (clr_en) clr_vec[clr_id] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            pend  <= '0;
        end else begin
            irq_q <= irq_in;
            pend  <= (pend & ~clr_vec) | rise;
        end
    end

    // R2
    pend_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(irq_in)) == '0));

    // R10
    pend_cleared_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !rise[clr_id]) |=> !pend[$past(clr_id)]);
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_prio_pkg::*;
#(
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eligible,
    input  logic          inta,
    input  logic [IW-1:0] win_id,
    output logic          intr,
    output logic          vec_strobe,
    output logic          ack,
    output logic [IW-1:0] sel_id
);
    ack_state_t state_q, state_d;

    assign ack = (state_q == ST_RAISE) && inta && eligible;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (eligible) state_d = ST_RAISE;
            ST_RAISE: begin
                if (ack)            state_d = ST_VECTOR;
                else if (!eligible) state_d = ST_IDLE;
            end
            ST_VECTOR:              state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sel_id  <= '0;
        end else begin
            state_q <= state_d;
            if (ack) sel_id <= win_id;
        end
    end

    always_comb begin
        intr       = 1'b0;
        vec_strobe = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RAISE:  intr = 1'b1;
            ST_VECTOR: vec_strobe = 1'b1;
            default:   ;
        endcase
    end

    // R5
    vector_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_strobe);

    // R5
    vector_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_strobe |=> !vec_strobe);

    // R4
    intr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr && !inta && eligible) |=> intr);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int unsigned N = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     irq_in,
    input  logic             cfg_we,
    input  logic [CFGAW-1:0] cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic             inta,
    output logic             intr,
    output logic             vec_valid,
    output logic [VECW-1:0]  vec_out
);
    localparam int unsigned IW = $clog2(N);
    localparam int unsigned BW = VECW - IW;

    logic [N-1:0]  pend, mask_q, isr_q, isr_d;
    logic [BW-1:0] base_q;
    logic          rot_en_q;
    logic [IW-1:0] rot_ptr_q, lowest;
    logic          pf, isf, eligible, ack, eoi, vec_strobe;
    logic [IW-1:0] pid, prank, iid, irank, sel_id;

    assign lowest   = rot_en_q ? rot_ptr_q : IW'(N - 1);
    assign eoi      = cfg_we && (cfg_addr == CFG_EOI);
    assign eligible = pf && (!isf || (prank < irank));

    irq_edge_latch #(.N(N), .IW(IW)) u_latch (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .clr_en(ack), .clr_id(pid), .pend(pend)
    );

    irq_prio_resolve #(.N(N), .IW(IW)) u_pend_res (
        .req(pend & ~mask_q), .lowest(lowest),
        .found(pf), .id(pid), .rank(prank)
    );

    irq_prio_resolve #(.N(N), .IW(IW)) u_isr_res (
        .req(isr_q), .lowest(lowest),
        .found(isf), .id(iid), .rank(irank)
    );

    irq_ack_fsm #(.IW(IW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .eligible(eligible), .inta(inta),
        .win_id(pid), .intr(intr), .vec_strobe(vec_strobe),
        .ack(ack), .sel_id(sel_id)
    );

    always_comb begin
        isr_d = isr_q;
        if (eoi && isf) isr_d[iid] = 1'b0;
        if (ack)        isr_d[pid] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            base_q    <= '0;
            rot_en_q  <= 1'b0;
            rot_ptr_q <= IW'(N - 1);
            isr_q     <= '0;
        end else begin
            isr_q <= isr_d;
            if (cfg_we && cfg_addr == CFG_MASK) mask_q   <= cfg_wdata[N-1:0];
            if (cfg_we && cfg_addr == CFG_BASE) base_q   <= cfg_wdata[BW-1:0];
            if (cfg_we && cfg_addr == CFG_MODE) rot_en_q <= cfg_wdata[0];
            if (eoi && isf && rot_en_q)         rot_ptr_q <= iid;
        end
    end

    assign vec_valid = vec_strobe;
    assign vec_out   = vec_strobe ? {base_q, sel_id} : '0;

    // R7
    nested_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && isf) |-> (prank < irank));

    // R8
    eoi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isf && !ack) |=> !isr_q[$past(iid)]);

    // R10
    isr_set_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !eoi) |=> isr_q[$past(pid)]);

    // R11
    eoi_empty_noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !isf && !ack) |=> (isr_q == '0));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       inta = 1'b0;
    logic       intr, vec_valid;
    logic [7:0] vec_out;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [4:0] base = '0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .inta(inta),
        .intr(intr), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    // Monitor: pops expected vectors as the design strobes them
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected vector", vec_out, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(vec_out == e, "R5/R6/R9 vector", vec_out, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            chk(1'b0, "watchdog", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic cfg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a == 2'd1) base = d[4:0];
    endtask

    task automatic pulse(input logic [7:0] m);
        @(negedge clk);
        irq_in = irq_in | m;
        repeat (2) @(negedge clk);
        irq_in = irq_in & ~m;
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(intr == 1'b0, req, intr, 0);
        end
    endtask

    // Driver: waits for intr, pushes the expected vector, pulses inta
    task automatic ack(input int id, input string req);
        int t = 0;
        @(negedge clk);
        while (!intr && t < 20) begin
            @(negedge clk);
            t++;
        end
        chk(intr == 1'b1, req, intr, 1);
        if (intr) begin
            exp_q.push_back({base, 3'(id)});
            inta = 1'b1;
            @(negedge clk);
            inta = 1'b0;
            chk(intr == 1'b0, "R10 intr drops after ack", intr, 0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(intr == 0, "R1 intr", intr, 0);
        chk(vec_valid == 0, "R1 vec_valid", vec_valid, 0);
        chk(vec_out == 0, "R1 vec_out", vec_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(intr == 0, "R1 intr after release", intr, 0);

        cfg(2'd1, 8'h1A);
        // R4 latency: edge sampled at k, intr after k+1
        @(negedge clk);
        irq_in[3] = 1'b1;
        @(negedge clk);
        chk(intr == 0, "R4 intr one edge after request", intr, 0);
        @(negedge clk);
        chk(intr == 1, "R4 intr two edges after request", intr, 1);
        irq_in[3] = 1'b0;
        quiet(0, "R4");
        ack(3, "R5 ack line 3");
        cfg(2'd3, 8'h00);
        quiet(5, "R10 no repeat without new edge");

        // R6 fixed priority, R7 nesting, R8 end of interrupt
        pulse(8'h24);
        ack(2, "R6 line 2 beats line 5");
        quiet(6, "R7 lower line blocked while 2 in service");
        pulse(8'h02);
        ack(1, "R7 higher line pre-empts");
        cfg(2'd3, 8'h00);
        quiet(6, "R8 eoi clears 1, line 2 still blocks 5");
        cfg(2'd3, 8'h00);
        ack(5, "R8 line 5 served after second eoi");
        cfg(2'd3, 8'h00);

        // R2 level held does not retrigger
        @(negedge clk);
        irq_in[4] = 1'b1;
        ack(4, "R2 line 4");
        cfg(2'd3, 8'h00);
        quiet(8, "R2 held level no retrigger");
        irq_in[4] = 1'b0;
        // R2 second edge while pending absorbed
        pulse(8'h40);
        pulse(8'h40);
        ack(6, "R2 line 6");
        cfg(2'd3, 8'h00);
        quiet(6, "R2 second edge absorbed");

        // R3 mask
        cfg(2'd0, 8'h80);
        pulse(8'h80);
        quiet(8, "R3 masked line silent");
        cfg(2'd0, 8'h00);
        ack(7, "R3 served after unmask");
        cfg(2'd3, 8'h00);

        // R11 eoi with empty in-service keeps rotation point
        cfg(2'd2, 8'h01);
        cfg(2'd3, 8'h00);
        pulse(8'h81);
        ack(0, "R11 rotation point unmoved");
        cfg(2'd3, 8'h00);
        // R9 rotating: 0 is now lowest
        pulse(8'h83);
        ack(1, "R9 line 1 highest after 0 rotated");
        quiet(4, "R7 nesting in rotating order");
        cfg(2'd3, 8'h00);
        ack(7, "R9 line 7 beats 0 after 1 rotated");
        cfg(2'd3, 8'h00);
        ack(0, "R9 line 0 last");
        cfg(2'd3, 8'h00);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5 all vectors seen", exp_q.size(), 0);

        summary();
        $finish;
    end
endmodule